// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver with Fixed-Phase Oversampling

This block takes the two data lines of a low-speed USB link and turns each incoming packet into a stream of bytes. It runs from a system clock at exactly ten times the bit rate. It does not use a clock-recovery loop. It waits for a falling edge on D- that moves the line from idle J to K, and it anchors a free-running phase counter on that edge. Every later bit is taken at the centre phase of that counter.

The leading synchronisation pattern alternates K and J and then ends with two K bits in a row. The receiver restarts its alignment on every J-to-K edge inside that pattern. It switches to data reception only when it has seen the double K.

After lock, the receiver does the following:
- It decodes NRZI.
- It drops the bit that the transmitter stuffs after six ones.
- It assembles bytes LSB first and reports each one with a single-cycle strobe.
- It ends the packet on SE0. SE0 is ignored at the first bit of a byte, because hubs may leave a trailing dribble bit there.

When the line returns to J, the receiver pulses end-of-packet. The byte count for the packet is valid at that pulse. A packet longer than the configured buffer raises an overflow flag, and no further bytes of that packet are delivered.

Top module: `usb_ls_rx`

## Requirements
- R1: Line codes: J is D+=0 with D-=1 and is the idle state; K is D+=1 with D-=0; SE0 is both lines low. After reset, byte_valid_o, eop_o, overflow_o and byte_cnt_o are all 0, and an idle J line produces no byte and no end-of-packet.
- R2: A J-to-K edge restarts a 10-clock bit phase counter, and each bit is sampled 5 clocks after the edge phase. The pattern K J K J K J K K, with each level held 10 clocks, locks the receiver, and the bits that follow are treated as data.
- R3: If the bit after the edge's K is not K, the attempt ends within two bit times and the search for a J-to-K edge resumes. A lone K between idle J bits yields no byte and no end-of-packet, and a following packet is received correctly.
- R4: NRZI decoding gives 1 when a sampled D- level equals the previous one and 0 when it differs. The reference for the first data bit is the last sync K. Bytes are assembled LSB first and presented on byte_o with a one-cycle byte_valid_o pulse.
- R5: After six consecutive decoded 1s the next bit is discarded. The run count includes the final sync bit. Bytes containing such runs (0xFF, 0x7E, 0x3F, 0xFC) are recovered intact.
- R6: SE0 on any bit position other than the first bit of a byte ends the packet, and a partial byte is discarded.
- R7: SE0 on the first bit position of a byte does not end the packet. It is decoded from its D- level, as K, and the bytes that follow are still delivered.
- R8: After the terminating SE0, eop_o pulses for one cycle only once the line is J again, even if SE0 lasts several bit times. byte_cnt_o then holds the number of delivered bytes until the next lock.
- R9: A complete byte that arrives when BUF_BYTES bytes are already delivered sets overflow_o and is not delivered. byte_cnt_o stays at BUF_BYTES, and eop_o still pulses. overflow_o clears at the next lock.
- R10: A single dribble bit between the last byte and SE0 adds no byte.
- R11: byte_valid_o and eop_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, ten times the bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dp_i | input | 1 | D+ line level |
| dm_i | input | 1 | D- line level |
| byte_o | output | 8 | Last received byte |
| byte_valid_o | output | 1 | One-cycle strobe for byte_o |
| eop_o | output | 1 | One-cycle end-of-packet pulse |
| byte_cnt_o | output | clog2(BUF_BYTES+1) | Bytes delivered in the current or last packet |
| overflow_o | output | 1 | Packet exceeded the buffer |

## Verification
The bench targets the following corner cases:
- **SE0 at a byte boundary.** A one-bit SE0 is placed exactly at the first bit of a middle byte. A receiver that checks SE0 there would cut the packet short and lose the remaining bytes.
- **Stuffing.** Byte values with runs of six ones, including one at the very end of a packet, are sent. Off-by-one stuffing logic, or a run count that does not start from the sync bit, would shift every following bit.
- **Packet endings.** Packets end with a dribble bit, with a truncated byte, and with a long SE0. Each case shows whether a partial byte leaks out and whether end-of-packet fires before J returns.
- **Overflow and false sync.** An overflowing packet checks that the count saturates and that the flag clears on the next packet. A lone K checks that a failed sync attempt leaves no trace.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;
  localparam int unsigned BYTE_W = 8;

  // encoding is {dm, dp}
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_K   = 2'b01,
    LN_J   = 2'b10,
    LN_SE1 = 2'b11
  } line_e;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_CHECK,
    ST_RECV,
    ST_WAITJ
  } rx_state_e;
endpackage

// File: rtl/usb_ls_rx_line.sv
module usb_ls_rx_line
  import usb_ls_rx_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  dp_i,
  input  logic  dm_i,
  output line_e line_o,
  output line_e prev_o
);
  logic [STAGES-1:0] dp_sr, dm_sr;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dp_sr <= '0;
        dm_sr <= '1;
      end else begin
        dp_sr <= dp_i;
        dm_sr <= dm_i;
      end
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dp_sr <= '0;
        dm_sr <= '1;
      end else begin
        dp_sr <= {dp_sr[STAGES-2:0], dp_i};
        dm_sr <= {dm_sr[STAGES-2:0], dm_i};
      end
    end
  end

  assign line_o = line_e'({dm_sr[STAGES-1], dp_sr[STAGES-1]});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= LN_J;
    else         prev_o <= line_o;
  end
endmodule

// File: rtl/usb_ls_rx_phase.sv
module usb_ls_rx_phase #(
  parameter  int unsigned OSR = 10,
  localparam int unsigned PW  = $clog2(OSR)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic strobe_o
);
  localparam logic [PW-1:0] MID  = PW'(OSR / 2);
  localparam logic [PW-1:0] LAST = PW'(OSR - 1);

  logic [PW-1:0] ph_q;

  // edge cycle is phase 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ph_q <= '0;
    else if (restart_i)    ph_q <= PW'(1);
    else if (ph_q == LAST) ph_q <= '0;
    else                   ph_q <= ph_q + 1'b1;
  end

  assign strobe_o = !restart_i && (ph_q == MID);
endmodule

// File: rtl/usb_ls_rx_deser.sv
module usb_ls_rx_deser
  import usb_ls_rx_pkg::*;
#(
  parameter  int unsigned STUFF_LEN = 6,
  localparam int unsigned RUN_W     = $clog2(STUFF_LEN + 1),
  localparam int unsigned IDX_W     = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              strobe_i,
  input  line_e             line_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_done_o,
  output logic              se0_end_o
);
  logic              prev_dm_q;
  logic [RUN_W-1:0]  run_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] sh_q;

  logic [1:0]        line_bits;
  logic              stuffed, first_bit, is_se0, dm_now, dbit;
  logic [BYTE_W-1:0] sh_next;

  assign line_bits = 2'(line_i);
  assign dm_now    = line_bits[1];
  assign is_se0    = (line_bits == 2'b00);
  assign stuffed   = (run_q == RUN_W'(STUFF_LEN));
  // SE0 ignored at first bit of a byte (hub dribble)
  assign first_bit = (idx_q == '0) && !stuffed;
  assign dbit      = (dm_now == prev_dm_q);
  assign sh_next   = {dbit, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_dm_q   <= 1'b0;
      run_q       <= '0;
      idx_q       <= '0;
      sh_q        <= '0;
      byte_o      <= '0;
      byte_done_o <= 1'b0;
      se0_end_o   <= 1'b0;
    end else begin
      byte_done_o <= 1'b0;
      se0_end_o   <= 1'b0;
      if (init_i) begin
        prev_dm_q <= 1'b0;        // last sync bit is K
        run_q     <= RUN_W'(1);   // and counts as a 1
        idx_q     <= '0;
        sh_q      <= '0;
      end else if (strobe_i) begin
        if (is_se0 && !first_bit) begin
          se0_end_o <= 1'b1;
        end else begin
          prev_dm_q <= dm_now;
          if (stuffed) begin
            run_q <= '0;
          end else begin
            run_q <= dbit ? run_q + 1'b1 : '0;
            sh_q  <= sh_next;
            idx_q <= idx_q + 1'b1;
            if (idx_q == '1) begin
              byte_o      <= sh_next;
              byte_done_o <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter  int unsigned OSR         = 10,
  parameter  int unsigned BUF_BYTES   = 8,
  parameter  int unsigned SYNC_STAGES = 2,
  parameter  int unsigned STUFF_LEN   = 6,
  localparam int unsigned CNT_W       = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dp_i,
  input  logic              dm_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              eop_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic              overflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BUF_BYTES);

  line_e             line_q, line_prev_q;
  rx_state_e         state_q;
  logic              sync_seen_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q, bv_q, eop_q;
  logic              edge_jk, restart, strobe, des_init, des_strobe;
  logic              byte_done, se0_end;
  logic [BYTE_W-1:0] des_byte;

  usb_ls_rx_line #(.STAGES(SYNC_STAGES)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dp_i   (dp_i),
    .dm_i   (dm_i),
    .line_o (line_q),
    .prev_o (line_prev_q)
  );

  assign edge_jk = (line_q == LN_K) && (line_prev_q == LN_J);
  assign restart = (state_q == ST_HUNT) && edge_jk;

  usb_ls_rx_phase #(.OSR(OSR)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .strobe_o  (strobe)
  );

  assign des_init   = (state_q == ST_CHECK) && strobe && (line_q == LN_K) && sync_seen_q;
  assign des_strobe = (state_q == ST_RECV) && strobe;

  usb_ls_rx_deser #(.STUFF_LEN(STUFF_LEN)) u_deser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (des_init),
    .strobe_i    (des_strobe),
    .line_i      (line_q),
    .byte_o      (des_byte),
    .byte_done_o (byte_done),
    .se0_end_o   (se0_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_HUNT;
      sync_seen_q <= 1'b0;
      cnt_q       <= '0;
      ovf_q       <= 1'b0;
      bv_q        <= 1'b0;
      eop_q       <= 1'b0;
    end else begin
      bv_q  <= 1'b0;
      eop_q <= 1'b0;
      unique case (state_q)
        ST_HUNT: begin
          if (edge_jk) begin
            state_q     <= ST_CHECK;
            sync_seen_q <= 1'b0;
          end
        end
        ST_CHECK: begin
          if (strobe) begin
            if (line_q != LN_K) begin
              state_q <= ST_HUNT;
            end else if (sync_seen_q) begin
              state_q <= ST_RECV;
              cnt_q   <= '0;
              ovf_q   <= 1'b0;
            end else begin
              sync_seen_q <= 1'b1;
            end
          end
        end
        ST_RECV: begin
          if (byte_done) begin
            if (ovf_q || cnt_q == CNT_MAX) begin
              ovf_q <= 1'b1;
            end else begin
              bv_q  <= 1'b1;
              cnt_q <= cnt_q + 1'b1;
            end
          end
          if (se0_end) state_q <= ST_WAITJ;
        end
        ST_WAITJ: begin
          if (line_q == LN_J) begin
            eop_q   <= 1'b1;
            state_q <= ST_HUNT;
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  assign byte_o       = des_byte;
  assign byte_valid_o = bv_q;
  assign eop_o        = eop_q;
  assign byte_cnt_o   = cnt_q;
  assign overflow_o   = ovf_q;
endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk
  import usb_ls_rx_pkg::*;
#(
  parameter  int unsigned BUF_BYTES = 8,
  localparam int unsigned CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byte_valid_o,
  input logic             eop_o,
  input logic             overflow_o,
  input logic [CNT_W-1:0] byte_cnt_o,
  input line_e            line_q
);
  // R11
  byte_eop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_valid_o && eop_o));

  // R4
  byte_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  // R8
  eop_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> !eop_o);

  // R8
  eop_after_j_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> $past(line_q == LN_J));

  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cnt_o <= CNT_W'(BUF_BYTES));

  // R9
  ovf_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(byte_cnt_o) == CNT_W'(BUF_BYTES));

  // R9
  no_byte_in_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> !byte_valid_o);
endmodule

bind usb_ls_rx usb_ls_rx_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_valid_o (byte_valid_o),
  .eop_o        (eop_o),
  .overflow_o   (overflow_o),
  .byte_cnt_o   (byte_cnt_o),
  .line_q       (line_q)
);

// File: tb/usb_ls_rx_tb.sv
`timescale 1ns/1ps
module usb_ls_rx_tb;
  localparam int OSR = 10;
  localparam int BUF = 8;
  localparam int CW  = $clog2(BUF + 1);

  typedef struct packed {
    logic [3:0]  n;
    logic [95:0] data;
    logic [2:0]  tail;
    logic [3:0]  glitch;
    logic [3:0]  se0_len;
    logic [3:0]  exp_n;
    logic        exp_ovf;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 96'h5AC3,                  3'd0, 4'hF, 4'd2, 4'd2, 1'b0},
    '{4'd3, 96'h01FFFF,                3'd0, 4'hF, 4'd2, 4'd3, 1'b0},
    '{4'd1, 96'h00,                    3'd1, 4'hF, 4'd2, 4'd1, 1'b0},
    '{4'd4, 96'hA5550000,              3'd0, 4'd2, 4'd2, 4'd4, 1'b0},
    '{4'd9, 96'h09_0807060504030201,   3'd0, 4'hF, 4'd2, 4'd8, 1'b1},
    '{4'd3, 96'hFC3F7E,                3'd0, 4'hF, 4'd6, 4'd3, 1'b0},
    '{4'd2, 96'h3412,                  3'd3, 4'hF, 4'd2, 4'd2, 1'b0}
  };
  localparam string TAGS [NV] = '{"R4", "R5", "R10", "R7", "R9", "R8", "R6"};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dp_i = 1'b0;
  logic dm_i = 1'b1;
  logic [7:0]    byte_o;
  logic          byte_valid_o, eop_o, overflow_o;
  logic [CW-1:0] byte_cnt_o;

  always #4 clk = ~clk;

  usb_ls_rx #(.OSR(OSR), .BUF_BYTES(BUF)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .dp_i         (dp_i),
    .dm_i         (dm_i),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .eop_o        (eop_o),
    .byte_cnt_o   (byte_cnt_o),
    .overflow_o   (overflow_o)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int rx_n = 0;
  int eop_n = 0;
  int eop_cnt = 0;
  int eop_early = 0;
  logic [7:0] rx_bytes [16];
  logic lvl;

  always @(negedge clk) begin
    if (byte_valid_o) begin
      if (rx_n < 16) rx_bytes[rx_n] = byte_o;
      rx_n = rx_n + 1;
    end
    if (eop_o) begin
      eop_n   = eop_n + 1;
      eop_cnt = int'(byte_cnt_o);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp_v);
    tests++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic drive_lvl(input logic dp, input logic dm);
    dp_i = dp;
    dm_i = dm;
    repeat (OSR) @(negedge clk);
  endtask

  task automatic emit(input logic d, input logic as_se0);
    if (!d) lvl = !lvl;
    if (as_se0) drive_lvl(1'b0, 1'b0);
    else        drive_lvl(!lvl, lvl);
  endtask

  task automatic send_pkt(input vec_t v);
    int ones;
    rx_n  = 0;
    eop_n = 0;
    lvl   = 1'b1;
    repeat (3) drive_lvl(1'b0, 1'b1);
    for (int k = 0; k < 8; k++) emit(k == 7, 1'b0);   // sync pattern
    ones = 1;
    for (int i = 0; i < int'(v.n); i++) begin
      for (int k = 0; k < 8; k++) begin
        logic d;
        d = v.data[8*i+k];
        emit(d, (i == int'(v.glitch)) && (k == 0));
        if (d) ones++;
        else   ones = 0;
        if (ones == 6) begin
          emit(1'b0, 1'b0);
          ones = 0;
        end
      end
    end
    for (int t = 0; t < int'(v.tail); t++) emit(1'b0, 1'b0);
    for (int s = 0; s < int'(v.se0_len); s++) drive_lvl(1'b0, 1'b0);
    eop_early = eop_n;
    repeat (3) drive_lvl(1'b0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R2 watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "byte_valid_o", int'(byte_valid_o), 0);
    chk("R1", "eop_o", int'(eop_o), 0);
    chk("R1", "overflow_o", int'(overflow_o), 0);
    chk("R1", "byte_cnt_o", int'(byte_cnt_o), 0);
    repeat (5) drive_lvl(1'b0, 1'b1);
    chk("R1", "idle bytes", rx_n, 0);
    chk("R1", "idle eop", eop_n, 0);

    // R3 lone K: sync attempt abandoned
    rx_n  = 0;
    eop_n = 0;
    drive_lvl(1'b1, 1'b0);
    repeat (6) drive_lvl(1'b0, 1'b1);
    chk("R3", "abort bytes", rx_n, 0);
    chk("R3", "abort eop", eop_n, 0);

    // table walk: R2 lock on every packet
    for (int vi = 0; vi < NV; vi++) begin
      send_pkt(VECS[vi]);
      chk("R2", "locked byte count", rx_n, int'(VECS[vi].exp_n));
      for (int b = 0; b < int'(VECS[vi].exp_n); b++)
        chk(TAGS[vi], "byte value", int'(rx_bytes[b]), int'(VECS[vi].data[8*b +: 8]));
      chk("R8", "eop before J", eop_early, 0);
      chk("R8", "eop pulses", eop_n, 1);
      chk("R8", "count at eop", eop_cnt, int'(VECS[vi].exp_n));
      chk("R8", "count held", int'(byte_cnt_o), int'(VECS[vi].exp_n));
      chk("R9", "overflow", int'(overflow_o), int'(VECS[vi].exp_ovf));
    end

    // R3 packet after abort still received (and abort again before it)
    drive_lvl(1'b1, 1'b0);
    repeat (4) drive_lvl(1'b0, 1'b1);
    send_pkt(VECS[0]);
    chk("R3", "recover bytes", rx_n, 2);
    chk("R3", "recover byte0", int'(rx_bytes[0]), 8'hC3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule